// File: doc/BRIEF.md
# I2C Bus Clear Recovery Engine

This block frees an I2C bus when the master has lost arbitration in single-master operation because a slave is holding SDA low indefinitely. Software first writes a configuration word with the pulse threshold, the SCL half-period and the option bits. It then writes the same word again with the enable bit set. The engine clocks SCL while it watches SDA. It can optionally finish with a STOP condition. When the sequence ends, the engine raises a maskable completion interrupt and records in a status register whether SDA came free.

Both bus lines are open-drain. The engine controls them through active-high "pull low" enables, and it observes SDA through a synchronizer. The register port is a simple single-cycle write strobe with a combinational read mux, indexed by a 2-bit word address: 0 configuration, 1 recovery status, 2 interrupt status, 3 interrupt mask.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset both line enables are 0, `irq` is 0 and all four registers read 0.
- R2: A configuration write while idle stores the threshold (bits 23:16), the half-period in clocks (bits 15:8), terminate mode (bit 1) and STOP request (bit 2). Bit 0 set in that write starts a sequence. Read-back bit 0 is 1 while the sequence runs and 0 once it has finished.
- R3: Each SCL pulse pulls SCL low for H clocks and then releases it for H clocks, where H is the half-period field.
- R4: With terminate mode off, exactly threshold-count pulses are issued, whatever SDA does.
- R5: With terminate mode on, pulsing stops after the first pulse at whose end the synchronized SDA is high, with at most threshold-count pulses.
- R6: With STOP requested, the pulses are followed by three H-clock steps: SDA pulled low while SCL is pulled low, then SCL released, then SDA released. SDA is never pulled low at any other time.
- R7: Counting from the clock edge that accepts the enabling write, completion sets interrupt-status bit 11 at edge 2·H·n + 3·H·s, where n is the number of pulses and s is 1 if STOP was requested (0 otherwise).
- R8: Status bit 0 holds the SDA level sampled at the end of the last pulse: 1 means the bus recovered, 0 means the threshold ran out with SDA low.
- R9: `irq` equals interrupt-status bit 11 AND mask bit 11. Writing 1 to status bit 11 clears it, and writing 0 leaves it set.
- R10: Configuration writes made while a sequence runs are ignored, and they neither alter the stored fields nor restart the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | SDA line level |
| irq | output | 1 | Completion interrupt |

## Verification
The busy flag is visible one cycle after the edge that accepts the enabling write. The completion bit appears exactly 2·H·n + 3·H·s edges after that write edge. The bench measures this distance by polling at every falling clock edge and compares it with the arithmetic value. A release of SDA by the slave model reaches the sampler two edges later through the synchronizer, so the sweeps use H of 4 and 5. With those values a release caused by a rising SCL lands inside the same high phase, which lets the expected pulse count be computed as min(release pulse, threshold). All outputs and read data are sampled at falling edges, away from the edge at which the registers update.

// File: rtl/i2c_brc_pkg.sv
`timescale 1ns/1ps
// Shared register map constants and sequencer state type for the bus clear engine.
package i2c_brc_pkg;
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] ADR_CFG  = 2'd0;
    localparam logic [REG_AW-1:0] ADR_STAT = 2'd1;
    localparam logic [REG_AW-1:0] ADR_INT  = 2'd2;
    localparam logic [REG_AW-1:0] ADR_MASK = 2'd3;

    localparam int BIT_EN   = 0;
    localparam int BIT_TERM = 1;
    localparam int BIT_STOP = 2;
    localparam int BIT_REC  = 0;
    localparam int BIT_DONE = 11;
    localparam int HALF_LSB = 8;
    localparam int THR_LSB  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } seq_state_t;
endpackage

// File: rtl/i2c_brc_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for an asynchronous bus line.
// Assumes STAGES >= 2; resets to RST_VAL (idle bus level).
module i2c_brc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff_q;

    // Shift the raw line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ff_q <= {STAGES{RST_VAL}};
        else        ff_q <= {ff_q[STAGES-2:0], d};
    end

    assign q = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_brc_regs.sv
`timescale 1ns/1ps
// Register file: configuration, recovery status, interrupt status (write 1
// to clear) and interrupt mask. Gates configuration writes while busy and
// issues a one-cycle start when the enable bit is written while idle.
// Assumes HALF_LSB + HALF_W <= THR_LSB and THR_LSB + THR_W <= 32.
module i2c_brc_regs
    import i2c_brc_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              rec_next,
    output logic [31:0]       rdata,
    output logic              start,
    output logic [HALF_W-1:0] cfg_half,
    output logic [THR_W-1:0]  cfg_thr,
    output logic              cfg_term,
    output logic              cfg_stop,
    output logic              irq
);
    localparam logic [31:0] THR_FIELD  = ((32'd1 << THR_W) - 32'd1) << THR_LSB;
    localparam logic [31:0] HALF_FIELD = ((32'd1 << HALF_W) - 32'd1) << HALF_LSB;
    localparam logic [31:0] CFG_MASK   = THR_FIELD | HALF_FIELD
                                       | (32'd1 << BIT_TERM) | (32'd1 << BIT_STOP);

    logic [31:0] cfg_q;
    logic        stat_q;
    logic        int_q;
    logic        mask_q;
    logic        cfg_wr;
    logic        int_clr;

    assign cfg_wr  = we && (addr == ADR_CFG) && !busy;
    assign start   = cfg_wr && wdata[BIT_EN];
    assign int_clr = we && (addr == ADR_INT) && wdata[BIT_DONE];

    // Store configuration fields; enable is not stored (it reads as busy).
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= wdata & CFG_MASK;
    end

    // Capture the recovery outcome when the sequence finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)    stat_q <= 1'b0;
        else if (done) stat_q <= rec_next;
    end

    // Completion flag: set on done (wins over a clear), cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n)       int_q <= 1'b0;
        else if (done)    int_q <= 1'b1;
        else if (int_clr) int_q <= 1'b0;
    end

    // Interrupt mask bit for completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask_q <= 1'b0;
        else if (we && (addr == ADR_MASK))  mask_q <= wdata[BIT_DONE];
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADR_CFG:  rdata = cfg_q | {31'd0, busy};
            ADR_STAT: rdata = 32'(stat_q) << BIT_REC;
            ADR_INT:  rdata = 32'(int_q) << BIT_DONE;
            default:  rdata = 32'(mask_q) << BIT_DONE;
        endcase
    end

    assign cfg_half = cfg_q[HALF_LSB +: HALF_W];
    assign cfg_thr  = cfg_q[THR_LSB +: THR_W];
    assign cfg_term = cfg_q[BIT_TERM];
    assign cfg_stop = cfg_q[BIT_STOP];
    assign irq      = int_q & mask_q;

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_q));
    a_r7_done_sets_int: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> int_q);
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !done) |=> !int_q);
endmodule

// File: rtl/i2c_brc_seq.sv
`timescale 1ns/1ps
// Recovery sequencer: issues SCL pulses of programmable half-period, samples
// synchronized SDA at the end of each high phase, stops early in terminate
// mode, then optionally forms a STOP condition. Outputs are decoded from the
// state register. A zero half-period or threshold field acts as 1.
module i2c_brc_seq
    import i2c_brc_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic              cfg_term,
    input  logic              cfg_stop,
    input  logic              sda_s,
    output logic              busy,
    output logic              done,
    output logic              rec_next,
    output logic              scl_oe,
    output logic              sda_oe
);
    seq_state_t        st_q, st_d;
    logic [HALF_W-1:0] tick_q;
    logic [THR_W-1:0]  pulse_q;
    logic [THR_W-1:0]  pulse_inc;
    logic [HALF_W-1:0] half_eff;
    logic [THR_W-1:0]  thr_eff;
    logic              phase_end;
    logic              last_pulse;
    logic              rec_q;

    assign half_eff   = (cfg_half == '0) ? HALF_W'(1) : cfg_half;
    assign thr_eff    = (cfg_thr == '0) ? THR_W'(1) : cfg_thr;
    assign phase_end  = (tick_q == half_eff - HALF_W'(1));
    assign pulse_inc  = pulse_q + THR_W'(1);
    assign last_pulse = (pulse_inc == thr_eff) || (cfg_term && sda_s);

    // Next-state and completion decode.
    always_comb begin
        st_d = st_q;
        done = 1'b0;
        case (st_q)
            ST_IDLE:   if (start) st_d = ST_LOW;
            ST_LOW:    if (phase_end) st_d = ST_HIGH;
            ST_HIGH: begin
                if (phase_end) begin
                    if (!last_pulse)   st_d = ST_LOW;
                    else if (cfg_stop) st_d = ST_STOP_A;
                    else begin
                        st_d = ST_IDLE;
                        done = 1'b1;
                    end
                end
            end
            ST_STOP_A: if (phase_end) st_d = ST_STOP_B;
            ST_STOP_B: if (phase_end) st_d = ST_STOP_C;
            ST_STOP_C: begin
                if (phase_end) begin
                    st_d = ST_IDLE;
                    done = 1'b1;
                end
            end
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Half-period tick counter, restarted on every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)                                tick_q <= '0;
        else if ((st_d != st_q) || st_q == ST_IDLE) tick_q <= '0;
        else                                       tick_q <= tick_q + HALF_W'(1);
    end

    // Pulse counter and last SDA sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
            rec_q   <= 1'b0;
        end else if (st_q == ST_IDLE && start) begin
            pulse_q <= '0;
        end else if (st_q == ST_HIGH && phase_end) begin
            pulse_q <= pulse_inc;
            rec_q   <= sda_s;
        end
    end

    assign rec_next = (st_q == ST_HIGH) ? sda_s : rec_q;
    assign busy     = (st_q != ST_IDLE);
    assign scl_oe   = (st_q == ST_LOW) || (st_q == ST_STOP_A);
    assign sda_oe   = (st_q == ST_STOP_A) || (st_q == ST_STOP_B);

    a_r6_grab_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> scl_oe);
    a_r6_free_sda_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_oe);
    a_r3_low_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_oe) && half_eff > HALF_W'(1)) |=> scl_oe);
    a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pulse_q <= thr_eff));
    a_r5_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH && phase_end && pulse_inc != thr_eff && st_d != ST_LOW)
            |-> (cfg_term && sda_s));
endmodule

// File: rtl/i2c_bus_recover.sv
`timescale 1ns/1ps
// Top of the I2C bus clear recovery engine: register file, SDA synchronizer
// and recovery sequencer. Bus lines are open-drain: *_oe = 1 pulls low.
module i2c_bus_recover #(
    parameter int HALF_W      = 8,
    parameter int THR_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in,
    output logic        irq
);
    logic              start;
    logic              busy;
    logic              done;
    logic              rec_next;
    logic              sda_s;
    logic [HALF_W-1:0] cfg_half;
    logic [THR_W-1:0]  cfg_thr;
    logic              cfg_term;
    logic              cfg_stop;

    i2c_brc_regs #(.HALF_W(HALF_W), .THR_W(THR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .done(done), .rec_next(rec_next),
        .rdata(reg_rdata), .start(start), .cfg_half(cfg_half),
        .cfg_thr(cfg_thr), .cfg_term(cfg_term), .cfg_stop(cfg_stop),
        .irq(irq)
    );

    i2c_brc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
    );

    i2c_brc_seq #(.HALF_W(HALF_W), .THR_W(THR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_half(cfg_half),
        .cfg_thr(cfg_thr), .cfg_term(cfg_term), .cfg_stop(cfg_stop),
        .sda_s(sda_s), .busy(busy), .done(done), .rec_next(rec_next),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: tb/i2c_bus_recover_bench.sv
`timescale 1ns/1ps
// Sweep bench: threshold, half-period, options and slave release point.
module i2c_bus_recover_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        scl_oe, sda_oe, irq;
    logic        sda_line;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int hold_r = 0;
    logic mon_clr = 1'b0;
    int rises = 0, scl_pulses = 0, sda_cyc = 0, order_err = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;

    always #2 clk = ~clk;

    // Slave holds SDA low until it has seen hold_r rising SCL edges.
    assign sda_line = !sda_oe && (rises >= hold_r);

    i2c_bus_recover u_i2c_bus_recover (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .sda_in(sda_line), .irq(irq)
    );

    // Bus monitor at falling edges.
    always @(negedge clk) begin
        if (mon_clr) begin
            rises = 0; scl_pulses = 0; sda_cyc = 0; order_err = 0;
        end else begin
            if (!scl_oe && prev_scl) rises = rises + 1;
            if (scl_oe && !prev_scl) scl_pulses = scl_pulses + 1;
            if (sda_oe) sda_cyc = sda_cyc + 1;
            if (sda_oe && !prev_sda && !scl_oe) order_err = order_err + 1;
            if (!sda_oe && prev_sda && scl_oe) order_err = order_err + 1;
        end
        prev_scl = scl_oe;
        prev_sda = sda_oe;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    // One recovery run with arithmetic expectations.
    task automatic run(input int t, input int h, input int term, input int stp,
                       input int r, input int mk, input int chk_w0);
        logic [31:0] cfg, d;
        int n, lat, c;
        bit rec;
        hold_r = r;
        clear_mon();
        wr(2'd3, 32'(mk) << 11);
        cfg = (32'(t) << 16) | (32'(h) << 8) | (32'(stp) << 2) | (32'(term) << 1);
        wr(2'd0, cfg);
        wr(2'd0, cfg | 32'd1);
        addr = 2'd0;
        #1 chk("R2 busy readback", int'(rdata[0]), 1);
        if (term != 0) n = (r == 0) ? 1 : ((r < t) ? r : t);
        else           n = t;
        rec = (r <= t);
        lat = 2 * h * n + 3 * h * stp;
        c = 1;
        addr = 2'd2;
        forever begin
            @(negedge clk);
            c++;
            #1;
            if (rdata[11] || c > 3000) break;
        end
        chk("R7 completion latency", c - 1, lat);
        chk(term != 0 ? "R5 pulse count" : "R4 pulse count", scl_pulses - stp, n);
        chk("R3 SCL low per pulse: scl_oe idle at end", int'(scl_oe), 0);
        chk("R6 SDA pulled cycles", sda_cyc, 2 * h * stp);
        chk("R6 STOP ordering errors", order_err, 0);
        chk("R9 irq follows mask", int'(irq), mk);
        rd(2'd1, d); chk("R8 recovery status", int'(d[0]), int'(rec));
        rd(2'd0, d); chk("R2 enable self-clears", int'(d[0]), 0);
        chk("R2 threshold readback", int'(d[23:16]), t);
        if (chk_w0 != 0) begin
            wr(2'd2, 32'd0);
            rd(2'd2, d); chk("R9 write 0 keeps flag", int'(d[11]), 1);
        end
        wr(2'd2, 32'd1 << 11);
        rd(2'd2, d); chk("R9 write 1 clears flag", int'(d[11]), 0);
        chk("R9 irq low after clear", int'(irq), 0);
    endtask

    initial begin
        logic [31:0] d;
        int c;
        rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); chk("R1 register reset value", int'(d), 0);
        end
        chk("R1 scl_oe reset", int'(scl_oe), 0);
        chk("R1 sda_oe reset", int'(sda_oe), 0);
        chk("R1 irq reset", int'(irq), 0);

        // Sweep
        begin
            int thr_l[4]  = '{1, 2, 3, 9};
            int rel_l[7]  = '{0, 1, 2, 5, 9, 10, 200};
            for (int ti = 0; ti < 4; ti++)
                for (int h = 4; h <= 5; h++)
                    for (int tm = 0; tm < 2; tm++)
                        for (int sp = 0; sp < 2; sp++)
                            for (int ri = 0; ri < 7; ri++)
                                run(thr_l[ti], h, tm, sp, rel_l[ri], (ri + sp) % 2, ri == 3 ? 1 : 0);
        end

        // R10: config write while busy is ignored
        hold_r = 200;
        clear_mon();
        wr(2'd0, (32'd9 << 16) | (32'd4 << 8));
        wr(2'd0, (32'd9 << 16) | (32'd4 << 8) | 32'd1);
        repeat (5) @(negedge clk);
        we = 1'b1; addr = 2'd0; wdata = (32'd2 << 16) | (32'd4 << 8) | 32'h7;
        @(negedge clk);
        we = 1'b0;
        c = 7;
        addr = 2'd2;
        forever begin
            @(negedge clk);
            c++;
            #1;
            if (rdata[11] || c > 3000) break;
        end
        chk("R10 latency unchanged by busy write", c - 1, 2 * 4 * 9);
        chk("R10 pulse count unchanged", scl_pulses, 9);
        rd(2'd0, d);
        chk("R10 threshold kept", int'(d[23:16]), 9);
        chk("R10 options kept", int'(d[2:0]), 0);
        wr(2'd2, 32'd1 << 11);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule